// File: doc/BRIEF.md
# Periodic Clock Throttle Controller

This block caps average power in the fast operating mode by pulling the system off the fast clock for programmed stretches of time. It produces a clock-select output. When the output is high the fast clock is used. When it is low, bus cycles run on a fixed slower clock of about 9.2 MHz. A status output shows whether a low-speed stretch is in progress.

All timing is measured in DRAM refresh ticks, not in clock cycles. The block counts a trigger period of refresh ticks at full speed, then a duration period of refresh ticks at low speed, and repeats. Every switch between the two speeds happens on a refresh tick.

Throttling acts only when all of the following hold:
- the throttle enable bit is set;
- the fast-clock enable bit is set;
- the power manager reports its high-speed mode.

In every other power mode the clock select simply follows the fast-clock enable. Configuration is written and read back through a byte-wide interface addressed by index.

Top module: `clk_throttle`

## Requirements
- R1: After reset, every configuration byte reads 0x00, `clkSelFast` is 0 and `lowSpeedActive` is 0.
- R2: Throttling needs both bit 3 of index 0x77 (throttle enable) and bit 6 of index 0x61 (fast-clock enable). While bit 6 of 0x61 is clear, `clkSelFast` is 0 and no low-speed stretch ever starts.
- R3: Throttling acts only when `pmuMode` is 0 (high-speed mode). For any other `pmuMode` value, `clkSelFast` equals bit 6 of index 0x61 in the same cycle, whatever the throttle state.
- R4: Index 0x9F bits 7:4 hold the trigger count T and bits 3:0 hold the duration count D, both in refresh ticks. Number the refresh ticks seen since throttling became active k = 1, 2, and so on. The low-speed stretch covers every tick k for which (k-1) mod (T+D) lies in the range [T-1, T+D-2].
- R5: `lowSpeedActive` is 1 exactly during a low-speed stretch. It rises and falls only in the cycle after a cycle with `refreshTick` high. Without refresh ticks it never changes.
- R6: A value of 0 in either field of index 0x9F keeps throttling off. `clkSelFast` then equals the fast-clock enable.
- R7: If throttling stops being active during a low-speed stretch, the stretch is held until the next refresh tick. This covers clearing an enable and leaving high-speed mode. At that tick the stretch ends and the counters restart, so a later re-activation counts from k = 1.
- R8: Reading indices 0x61, 0x77 and 0x9F returns the byte last written there. Any other index reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe for the configuration bytes |
| regAddr | input | 8 | Configuration index |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| pmuMode | input | 2 | Power manager mode; 0 = high-speed mode |
| refreshTick | input | 1 | One-cycle pulse per DRAM refresh event |
| clkSelFast | output | 1 | 1 = fast clock, 0 = fixed slow bus clock |
| lowSpeedActive | output | 1 | 1 while a low-speed stretch is in progress |

## Verification
The throttle sequence is tried with the trigger and duration pairs (3,2), (1,1) and (2,4). These pairs separate mistakes in the trigger count, the duration count and the wrap back to the trigger phase, including the single-tick case. The same configuration is also held without any refresh ticks, which shows whether a transition ever happens off a tick. Activation is then broken in three ways: clearing the throttle enable, leaving high-speed mode, and zeroing a period field. These runs tell apart an immediate exit from an exit held until the next tick, and show whether the counters restart afterwards. With the fast-clock enable cleared, the bench confirms the throttle can never start. The register readback is checked for the mapped indices, and for an unmapped index both the read value and the absence of any write effect are checked.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam logic [7:0] IDX_HSCLK = 8'h61;
  localparam logic [7:0] IDX_CTRL  = 8'h77;
  localparam logic [7:0] IDX_TIMER = 8'h9F;
  localparam int HSCLK_BIT = 6;
  localparam int FEAT_BIT  = 3;

  typedef struct packed {
    logic advance;
    logic clear;
    logic enterLow;
    logic exitLow;
  } cttStrobe_t;
endpackage

// File: rtl/ctt_regs.sv
module ctt_regs
  import ctt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [2*CNT_W-1:0]  regWrData,
  output logic [2*CNT_W-1:0]  regRdData,
  output logic                hsClkEn,
  output logic                featEn,
  output logic [CNT_W-1:0]    trigPeriod,
  output logic [CNT_W-1:0]    durPeriod
);
  localparam int DATA_W = 2 * CNT_W;

  logic [DATA_W-1:0] hsClkReg, ctrlReg, timerReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hsClkReg <= '0;
      ctrlReg  <= '0;
      timerReg <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(IDX_HSCLK)) hsClkReg <= regWrData;
      if (regAddr == ADDR_W'(IDX_CTRL))  ctrlReg  <= regWrData;
      if (regAddr == ADDR_W'(IDX_TIMER)) timerReg <= regWrData;
    end
  end

  always_comb begin
    unique case (regAddr)
      ADDR_W'(IDX_HSCLK): regRdData = hsClkReg;
      ADDR_W'(IDX_CTRL):  regRdData = ctrlReg;
      ADDR_W'(IDX_TIMER): regRdData = timerReg;
      default:            regRdData = '0;
    endcase
  end

  assign hsClkEn    = hsClkReg[HSCLK_BIT];
  assign featEn     = ctrlReg[FEAT_BIT];
  assign trigPeriod = timerReg[DATA_W-1:CNT_W];
  assign durPeriod  = timerReg[CNT_W-1:0];
endmodule

// File: rtl/ctt_ctrl.sv
module ctt_ctrl
  import ctt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       active,
  input  logic       refreshTick,
  input  logic       cntHit,
  output cttStrobe_t strobes,
  output logic       lowSpeed
);
  always_comb begin
    strobes = '0;
    if (!active) begin
      if (!lowSpeed) begin
        strobes.clear = 1'b1;
      end else if (refreshTick) begin
        strobes.exitLow = 1'b1;
        strobes.clear   = 1'b1;
      end
    end else if (refreshTick) begin
      if (cntHit) begin
        strobes.clear    = 1'b1;
        strobes.enterLow = !lowSpeed;
        strobes.exitLow  = lowSpeed;
      end else begin
        strobes.advance = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lowSpeed <= 1'b0;
    else if (strobes.enterLow) lowSpeed <= 1'b1;
    else if (strobes.exitLow) lowSpeed <= 1'b0;
  end

  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowSpeed) |-> $past(refreshTick)); // R5
  AST_FALL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lowSpeed) |-> $past(refreshTick)); // R5
  AST_ENTER_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lowSpeed) |-> $past(active)); // R2
endmodule

// File: rtl/ctt_dp.sv
module ctt_dp
  import ctt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cttStrobe_t       strobes,
  input  logic             lowSpeed,
  input  logic [CNT_W-1:0] trigPeriod,
  input  logic [CNT_W-1:0] durPeriod,
  output logic             cntHit
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] target;
  logic [EXT_W-1:0] nextCnt;

  assign target  = lowSpeed ? durPeriod : trigPeriod;
  assign nextCnt = EXT_W'(tickCnt) + EXT_W'(1);
  assign cntHit  = nextCnt >= EXT_W'(target);

  always_ff @(posedge clk) begin
    if (!rstN) tickCnt <= '0;
    else if (strobes.clear) tickCnt <= '0;
    else if (strobes.advance) tickCnt <= nextCnt[CNT_W-1:0];
  end

  AST_ADV_CLR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.advance, strobes.clear})); // R4
  AST_ENTER_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterLow |-> cntHit); // R4
endmodule

// File: rtl/clk_throttle.sv
module clk_throttle
  import ctt_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 4,
  parameter int MODE_W  = 2,
  parameter int HS_MODE = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [2*CNT_W-1:0]  regWrData,
  output logic [2*CNT_W-1:0]  regRdData,
  input  logic [MODE_W-1:0]   pmuMode,
  input  logic                refreshTick,
  output logic                clkSelFast,
  output logic                lowSpeedActive
);
  logic hsClkEn, featEn, modeIsHs, active, lowSpeed, cntHit;
  logic [CNT_W-1:0] trigPeriod, durPeriod;
  cttStrobe_t strobes;

  ctt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hsClkEn(hsClkEn),
    .featEn(featEn), .trigPeriod(trigPeriod), .durPeriod(durPeriod)
  );

  assign modeIsHs = pmuMode == MODE_W'(HS_MODE);
  assign active   = featEn && hsClkEn && modeIsHs
                    && (trigPeriod != '0) && (durPeriod != '0);

  ctt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .active(active), .refreshTick(refreshTick),
    .cntHit(cntHit), .strobes(strobes), .lowSpeed(lowSpeed)
  );

  ctt_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lowSpeed(lowSpeed),
    .trigPeriod(trigPeriod), .durPeriod(durPeriod), .cntHit(cntHit)
  );

  assign clkSelFast     = hsClkEn && !(lowSpeed && modeIsHs);
  assign lowSpeedActive = lowSpeed;
endmodule

// File: tb/clk_throttle_tb.sv
module clk_throttle_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic [1:0] pmuMode = 2'd0;
  logic       refreshTick = 1'b0;
  logic       clkSelFast, lowSpeedActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  expLow;
    logic  expFast;
    string req;
  } expItem_t;
  expItem_t sbq[$];

  always #5 clk = ~clk;

  clk_throttle dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pmuMode(pmuMode),
    .refreshTick(refreshTick), .clkSelFast(clkSelFast),
    .lowSpeedActive(lowSpeedActive)
  );

  // monitor: pops expected items and compares against outputs
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      expItem_t it;
      it = sbq.pop_front();
      checks++;
      if (lowSpeedActive !== it.expLow || clkSelFast !== it.expFast) begin
        errors++;
        $display("FAIL %s: low=%b fast=%b expected low=%b fast=%b",
                 it.req, lowSpeedActive, clkSelFast, it.expLow, it.expFast);
      end
    end
  end

  task automatic expectNow(input logic expLow, input logic expFast, input string req);
    expItem_t it;
    it.expLow = expLow; it.expFast = expFast; it.req = req;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic tickExpect(input logic expLow, input logic expFast, input string req);
    @(negedge clk);
    refreshTick = 1'b1;
    @(posedge clk);
    #2 refreshTick = 1'b0;
    begin
      expItem_t it;
      it.expLow = expLow; it.expFast = expFast; it.req = req;
      sbq.push_back(it);
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #2 regWrEn = 1'b0;
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s: read idx %h got %h expected %h", req, a, regRdData, exp);
    end
  endtask

  // run n ticks of an active (T,D) sequence, expectation from R4 formula
  task automatic runPattern(input int t, input int d, input int n);
    for (int k = 1; k <= n; k++) begin
      int ph;
      logic lo;
      ph = (k - 1) % (t + d);
      lo = (ph >= t - 1) && (ph <= t + d - 2);
      tickExpect(lo, !lo, "R4");
    end
  endtask

  task automatic quiesce();
    wr(8'h77, 8'h00);
    tickExpect(1'b0, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    expectNow(1'b0, 1'b0, "R1");
    rdCheck(8'h61, 8'h00, "R1");
    rdCheck(8'h77, 8'h00, "R1");
    rdCheck(8'h9F, 8'h00, "R1");

    // R2: fast clock enable clear blocks throttling
    wr(8'h77, 8'h08); wr(8'h9F, 8'h11);
    for (int i = 0; i < 4; i++) tickExpect(1'b0, 1'b0, "R2");

    // R8 readback and unmapped index
    wr(8'h61, 8'h40);
    rdCheck(8'h61, 8'h40, "R8");
    rdCheck(8'h77, 8'h08, "R8");
    wr(8'h55, 8'hFF);
    rdCheck(8'h55, 8'h00, "R8");
    rdCheck(8'h9F, 8'h11, "R8");
    rdCheck(8'h61, 8'h40, "R8");
    quiesce();

    // R4 patterns
    wr(8'h9F, 8'h32); wr(8'h77, 8'h08);
    runPattern(3, 2, 11);
    quiesce();
    wr(8'h9F, 8'h11); wr(8'h77, 8'h08);
    runPattern(1, 1, 6);
    quiesce();
    wr(8'h9F, 8'h24); wr(8'h77, 8'h08);
    runPattern(2, 4, 13);
    quiesce();

    // R5: no ticks, no change
    wr(8'h9F, 8'h11); wr(8'h77, 8'h08);
    repeat (20) @(negedge clk);
    expectNow(1'b0, 1'b1, "R5");
    tickExpect(1'b1, 1'b0, "R5");
    repeat (15) @(negedge clk);
    expectNow(1'b1, 1'b0, "R5");
    quiesce();

    // R7: disable mid-stretch holds until next tick
    wr(8'h9F, 8'h13); wr(8'h77, 8'h08);
    tickExpect(1'b1, 1'b0, "R7");
    wr(8'h77, 8'h00);
    expectNow(1'b1, 1'b0, "R7");
    tickExpect(1'b0, 1'b1, "R7");
    wr(8'h77, 8'h08);
    tickExpect(1'b1, 1'b0, "R7");

    // R3 / R7: leave high-speed mode mid-stretch
    @(negedge clk); pmuMode = 2'd2;
    expectNow(1'b1, 1'b1, "R3");
    tickExpect(1'b0, 1'b1, "R7");
    tickExpect(1'b0, 1'b1, "R3");
    wr(8'h61, 8'h00);
    expectNow(1'b0, 1'b0, "R3");
    wr(8'h61, 8'h40);
    @(negedge clk); pmuMode = 2'd0;
    tickExpect(1'b1, 1'b0, "R7");
    quiesce();

    // R6: zero fields
    wr(8'h9F, 8'h03); wr(8'h77, 8'h08);
    for (int i = 0; i < 5; i++) tickExpect(1'b0, 1'b1, "R6");
    wr(8'h9F, 8'h30);
    for (int i = 0; i < 5; i++) tickExpect(1'b0, 1'b1, "R6");

    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule